// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block is the target side of a two-wire serial memory. A system clock oversamples the serial clock and data lines. The block finds Start and Stop conditions and decodes a device select byte. It then moves single bytes between the bus and an internal register array of `MEM_BYTES` bytes. The array size is a power of two from 128 to 2048. The data line is never driven high. The block only asserts `sda_oe`, which an open-drain pad uses to pull the line low for acknowledges and for zero data bits.

A transfer starts with a device select byte. When its direction bit calls for a write, a one-byte word address follows, and then the data bytes, each stored where the internal address counter points. When the direction bit calls for a read, bytes are returned from the counter position for as long as the master acknowledges. A random read is a write of only the word address, then a repeated Start and a read. A write-control pin blocks stores to the array. A power-good input holds the block deaf to the bus until power is stable.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After `rst_n` is low on a clock edge, `sda_oe` is 0, the address counter is 0 and every array byte reads 0x00.
- R2: The block acknowledges a device select byte only when its four most significant bits are 1010 and its bits 3, 2, 1 equal `chip_en[2]`, `chip_en[1]`, `chip_en[0]`. Any other value gets no acknowledge, and the bus is then ignored until the next Start.
- R3: Bit 0 of the device select byte sets the direction: 0 makes the next byte a word address, and 1 starts returning data at once.
- R4: For each accepted byte, `sda_oe` is 1 for the whole high phase of the ninth SCL pulse. During the high phase of the eight bits the master sends, it is 0.
- R5: A data byte received in a write is stored at the counter address, and the counter then advances by one.
- R6: The word address byte loads the counter's low min(8, log2 `MEM_BYTES`) bits. Any higher counter bits keep their value.
- R7: A read returns the byte at the counter, most significant bit first (`sda_oe` = inverse of the bit while SCL is high). The counter advances by one after each byte sent.
- R8: Reading continues while the master acknowledges (SDA low on the ninth pulse). A not-acknowledge ends the read and leaves SDA released until the next Start.
- R9: The counter wraps from `MEM_BYTES`-1 to 0 on both reads and writes.
- R10: While `wr_ctrl` is 1, the device select and word address bytes are still acknowledged. Data bytes get no acknowledge, and both the array and the counter stay unchanged by them.
- R11: While `por_ok` is 0, `sda_oe` stays 0, the bus is ignored and the counter is cleared to 0. The array keeps its contents. After `por_ok` returns to 1, the block waits idle for a Start.
- R12: `sda_oe` changes only while SCL is low, except when a Start or Stop releases it.
- R13: A Start seen in the middle of any byte restarts device select decoding. A Stop returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Power-good; 0 holds the block deaf to the bus |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| chip_en | input | 3 | Strap levels compared with device select bits 3..1 |
| wr_ctrl | input | 1 | 1 blocks every store to the array |

## Verification
Every reaction of the block comes from an SCL falling edge that has passed two synchroniser flops, one edge-detect flop and the output register. So `sda_oe` settles about four clocks after SCL falls and holds until the next fall. The bench holds each SCL half-period for 20 clocks. It compares `sda_oe` with its reference model on every clock of each SCL high phase, where the value must already be final and steady. Array and counter effects cannot be seen in the transfer that causes them. They are checked in a later read, whose data bits the model predicts from its own copy of the array and counter.

// File: rtl/i2c_eeprom_pkg.sv
// Package: shared types and constants for the serial memory slave.
// Assumes: byte-wide transfers with a ninth acknowledge clock.
package i2c_eeprom_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,    // waiting for a Start
        PH_DEVSEL,  // receiving the device select byte
        PH_WADDR,   // receiving the word address
        PH_WDATA,   // receiving data bytes to store
        PH_RDATA    // sending data bytes
    } phase_t;

    localparam logic [3:0] DEV_TYPE   = 4'b1010;
    localparam int         BYTE_BITS  = 8;
    localparam logic [3:0] CNT_ACK    = 4'd8;  // eight bits done, ack clock next
    localparam logic [3:0] CNT_ACKHI  = 4'd9;  // inside the ack clock
endpackage

// File: rtl/i2c_line_sampler.sv
// Module: i2c_line_sampler
// Brings SCL and SDA into the clock domain through a synchroniser chain and
// derives one-cycle SCL edge strobes and Start/Stop strobes.
// Assumes: clk runs at least eight times faster than SCL; the lines idle high.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_chain;
    logic [LAST:0] sda_chain;
    logic          scl_d;
    logic          sda_d;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[LAST-1:0], scl_i};
            sda_chain <= {sda_chain[LAST-1:0], sda_i};
            scl_d     <= scl_chain[LAST];
            sda_d     <= sda_chain[LAST];
        end
    end

    // Edge and bus-condition strobes.
    always_comb begin
        scl_s     = scl_chain[LAST];
        sda_s     = sda_chain[LAST];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_eeprom_store.sv
// Module: i2c_eeprom_store
// Register array holding the memory bytes, plus the shared address counter.
// Assumes: MEM_BYTES is a power of two; at most one of we/rd_step/ld_addr per cycle.
module i2c_eeprom_store #(
    parameter int MEM_BYTES = 256,
    parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              we,
    input  logic [7:0]        wdata,
    input  logic              rd_step,
    input  logic              ld_addr,
    input  logic [7:0]        ld_byte,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] addr
);
    localparam int              LOAD_W   = (ADDR_W < 8) ? ADDR_W : 8;
    localparam logic [ADDR_W-1:0] LAST_ADR = ADDR_W'(MEM_BYTES - 1);

    logic [7:0]        mem [MEM_BYTES];
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_inc;

    // Next sequential address with wrap at the top of the array.
    always_comb addr_inc = (addr_q == LAST_ADR) ? '0 : addr_q + 1'b1;

    // Array writes, address loads and counter steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
            addr_q <= '0;
        end else if (!live) begin
            addr_q <= '0;
        end else if (we) begin
            mem[addr_q] <= wdata;
            addr_q      <= addr_inc;
        end else if (rd_step) begin
            addr_q <= addr_inc;
        end else if (ld_addr) begin
            addr_q[LOAD_W-1:0] <= ld_byte[LOAD_W-1:0];
        end
    end

    // Read port follows the counter.
    always_comb begin
        rd_data = mem[addr_q];
        addr    = addr_q;
    end
endmodule

// File: rtl/i2c_eeprom_core.sv
// Module: i2c_eeprom_core
// Bus protocol engine: shifts bytes, decides acknowledges on the SCL fall that
// ends the eighth bit, and drives read data on SCL falls.
// Assumes: strobes from i2c_line_sampler; array read data is valid when sampled.
module i2c_eeprom_core
    import i2c_eeprom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       live,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       sda_s,
    input  logic [2:0] chip_en,
    input  logic       wr_ctrl,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       mem_we,
    output logic [7:0] wdata,
    output logic       rd_step,
    output logic       ld_addr,
    output logic [7:0] ld_byte
);
    phase_t     phase;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rnw;
    logic       mack_n;
    logic       dev_hit;
    logic [2:0] bit_idx;

    // Device select match and index of the next read bit.
    always_comb begin
        dev_hit = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_en);
        bit_idx = 3'(4'd7 - cnt);
    end

    // Protocol sequencing, shifting, acknowledge and read-data drive.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            rnw     <= 1'b0;
            mack_n  <= 1'b1;
            sda_oe  <= 1'b0;
            mem_we  <= 1'b0;
            rd_step <= 1'b0;
            ld_addr <= 1'b0;
        end else begin
            mem_we  <= 1'b0;
            rd_step <= 1'b0;
            ld_addr <= 1'b0;
            if (start_evt) begin
                phase  <= PH_DEVSEL;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (cnt < CNT_ACK) begin
                        cnt <= cnt + 1'b1;
                        if (phase != PH_RDATA) shreg <= {shreg[6:0], sda_s};
                    end else if (cnt == CNT_ACKHI && phase == PH_RDATA) begin
                        mack_n <= sda_s;
                    end
                end else if (scl_fall) begin
                    if (cnt == CNT_ACK) begin
                        cnt <= CNT_ACKHI;
                        case (phase)
                            PH_DEVSEL: begin
                                if (dev_hit) begin
                                    sda_oe <= 1'b1;
                                    rnw    <= shreg[0];
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_WADDR: begin
                                sda_oe  <= 1'b1;
                                ld_addr <= 1'b1;
                            end
                            PH_WDATA: begin
                                if (!wr_ctrl) begin
                                    sda_oe <= 1'b1;
                                    mem_we <= 1'b1;
                                end
                            end
                            PH_RDATA: begin
                                sda_oe  <= 1'b0;
                                rd_step <= 1'b1;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end else if (cnt == CNT_ACKHI) begin
                        cnt <= '0;
                        case (phase)
                            PH_DEVSEL: begin
                                if (rnw) begin
                                    phase  <= PH_RDATA;
                                    shreg  <= rd_data;
                                    sda_oe <= ~rd_data[7];
                                end else begin
                                    phase  <= PH_WADDR;
                                    sda_oe <= 1'b0;
                                end
                            end
                            PH_WADDR: begin
                                phase  <= PH_WDATA;
                                sda_oe <= 1'b0;
                            end
                            PH_WDATA: sda_oe <= 1'b0;
                            PH_RDATA: begin
                                if (!mack_n) begin
                                    shreg  <= rd_data;
                                    sda_oe <= ~rd_data[7];
                                end else begin
                                    phase  <= PH_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end else if (phase == PH_RDATA && cnt != 4'd0) begin
                        sda_oe <= ~shreg[bit_idx];
                    end
                end
            end
        end
    end

    // Byte presented to the array and the address loader.
    always_comb begin
        wdata   = shreg;
        ld_byte = shreg;
    end
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Module: i2c_eeprom_slave (top)
// Two-wire serial memory target: line sampler, protocol core and byte store.
// Assumes: open-drain pad outside drives the line low while sda_oe is 1.
module i2c_eeprom_slave #(
    parameter int MEM_BYTES   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_ok,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] chip_en,
    input  logic       wr_ctrl
);
    localparam int ADDR_W = $clog2(MEM_BYTES);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              mem_we;
    logic [7:0]        wdata;
    logic              rd_step;
    logic              ld_addr;
    logic [7:0]        ld_byte;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] addr;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (por_ok),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_eeprom_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (por_ok),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s),
        .chip_en   (chip_en),
        .wr_ctrl   (wr_ctrl),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .wdata     (wdata),
        .rd_step   (rd_step),
        .ld_addr   (ld_addr),
        .ld_byte   (ld_byte)
    );

    i2c_eeprom_store #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (por_ok),
        .we      (mem_we),
        .wdata   (wdata),
        .rd_step (rd_step),
        .ld_addr (ld_addr),
        .ld_byte (ld_byte),
        .rd_data (rd_data),
        .addr    (addr)
    );
endmodule

// File: rtl/i2c_eeprom_chk.sv
// Module: i2c_eeprom_chk
// Protocol checker bound into i2c_eeprom_slave; watches the data drive against
// the synchronised clock, bus conditions, power-good and array writes.
// Assumes: signal names of the top module as bound below.
module i2c_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic por_ok,
    input logic scl_s,
    input logic sda_oe,
    input logic mem_we,
    input logic wr_ctrl,
    input logic start_evt,
    input logic stop_evt
);
    // R12: drive is only asserted while SCL is low.
    a_r12_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
        $rose(sda_oe) |-> !scl_s);

    // R12, R13: release happens with SCL low or right after a Start/Stop.
    a_r12_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
        $fell(sda_oe) |-> (!scl_s || $past(start_evt || stop_evt)));

    // R10: no store while write control was high at decision time.
    a_r10_no_protected_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wr_ctrl));

    // R4: every stored byte is acknowledged.
    a_r4_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sda_oe);

    // R11: no drive while power is not good.
    a_r11_por_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> !sda_oe);

    // R13: a Stop releases the line.
    a_r13_stop_release: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
        stop_evt |=> !sda_oe);

    // R13: Start and Stop are never seen together.
    a_r13_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt}));
endmodule

bind i2c_eeprom_slave i2c_eeprom_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_ok    (por_ok),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .wr_ctrl   (wr_ctrl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
);

// File: tb/sim_i2c_eeprom_slave.sv
// Bench: behavioural bus master plus reference model (array, counter) that
// predicts sda_oe and compares it on every clock of each SCL high phase.
module sim_i2c_eeprom_slave;
    localparam int MEM_BYTES = 256;
    localparam int HALF      = 20;
    localparam logic [2:0] CE = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_ok = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int unsigned checks = 0;
    int unsigned fails = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [MEM_BYTES];
    int ref_addr = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_slave #(.MEM_BYTES(MEM_BYTES)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .por_ok  (por_ok),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .chip_en (CE),
        .wr_ctrl (wp)
    );

    function automatic int nxt(input int a);
        return (a + 1) % MEM_BYTES;
    endfunction

    // One SCL pulse; sda_oe compared every clock of the high phase (R12).
    task automatic clk_bit(input logic v, input logic exp_oe, input string tag);
        logic bad;
        logic seen;
        bad = 1'b0;
        seen = exp_oe;
        sda_m = v;
        repeat (HALF) @(negedge clk);
        scl_m = 1'b1;
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            if (sda_oe !== exp_oe) begin
                bad = 1'b1;
                seen = sda_oe;
            end
        end
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s (R12 window): sda_oe actual %b expected %b", tag, seen, exp_oe);
        end
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        repeat (HALF) @(negedge clk);
        scl_m = 1'b1;
        repeat (HALF) @(negedge clk);
        sda_m = 1'b0;
        repeat (HALF) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        repeat (HALF) @(negedge clk);
        scl_m = 1'b1;
        repeat (HALF) @(negedge clk);
        sda_m = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, tag);
        clk_bit(1'b1, exp_ack, {tag, " ack"});
    endtask

    task automatic get_byte(input logic [7:0] exp, input logic last, input string tag);
        for (int i = 7; i >= 0; i--) clk_bit(1'b1, ~exp[i], tag);
        clk_bit(last, 1'b0, {tag, " master ack"});
    endtask

    function automatic logic [7:0] dsel(input logic [2:0] ce, input logic rd);
        return {4'b1010, ce, rd};
    endfunction

    // Full byte write driven through the model (R3, R4, R5, R6, R10).
    task automatic do_write(input int a, input logic [7:0] d, input string tag);
        bus_start();
        put_byte(dsel(CE, 1'b0), 1'b1, {tag, " dev"});
        put_byte(8'(a), 1'b1, {tag, " addr"});
        ref_addr = a % MEM_BYTES;
        put_byte(d, ~wp, {tag, " data"});
        if (!wp) begin
            ref_mem[ref_addr] = d;
            ref_addr = nxt(ref_addr);
        end
        bus_stop();
    endtask

    // Read n bytes from the counter position (R7, R8).
    task automatic do_cur_read(input int n, input string tag);
        bus_start();
        put_byte(dsel(CE, 1'b1), 1'b1, {tag, " dev"});
        for (int k = 0; k < n; k++) begin
            get_byte(ref_mem[ref_addr], (k == n - 1), tag);
            ref_addr = nxt(ref_addr);
        end
        bus_stop();
    endtask

    // Address-only write, repeated Start, then read (R3, R6, R8).
    task automatic do_rand_read(input int a, input int n, input string tag);
        bus_start();
        put_byte(dsel(CE, 1'b0), 1'b1, {tag, " dev"});
        put_byte(8'(a), 1'b1, {tag, " addr"});
        ref_addr = a % MEM_BYTES;
        bus_start();
        put_byte(dsel(CE, 1'b1), 1'b1, {tag, " dev rd"});
        for (int k = 0; k < n; k++) begin
            get_byte(ref_mem[ref_addr], (k == n - 1), tag);
            ref_addr = nxt(ref_addr);
        end
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: idle drive after reset, array zero, counter zero.
        checks++;
        if (sda_oe !== 1'b0) begin
            fails++;
            $display("FAIL R1: sda_oe actual %b expected 0", sda_oe);
        end
        do_cur_read(2, "R1 R7 zero array");

        // R5, R6: byte writes; R8: sequential random read with master ack.
        do_write(8'h10, 8'hA5, "R5 R6 write");
        do_write(8'h11, 8'h3C, "R5 write");
        do_rand_read(8'h10, 2, "R8 R3 random read");
        do_cur_read(1, "R7 current read");

        // R2: wrong type code and wrong chip enable are not acknowledged.
        bus_start();
        put_byte(8'b1011_1010, 1'b0, "R2 bad type");
        put_byte(8'h10, 1'b0, "R2 ignored");
        bus_stop();
        bus_start();
        put_byte(dsel(3'b100, 1'b0), 1'b0, "R2 bad chip_en");
        put_byte(8'h10, 1'b0, "R2 ignored");
        bus_stop();

        // R9: write at top address wraps the counter.
        do_write(MEM_BYTES - 1, 8'h77, "R9 top write");
        do_cur_read(2, "R9 wrap read");
        do_rand_read(MEM_BYTES - 1, 2, "R9 read wrap");

        // R10: protected write keeps array and counter.
        wp = 1'b1;
        do_write(8'h10, 8'h00, "R10 protected");
        do_cur_read(1, "R10 counter kept");
        wp = 1'b0;
        do_rand_read(8'h10, 1, "R10 array kept");

        // R13: Start in mid-byte restarts decoding.
        bus_start();
        clk_bit(1'b1, 1'b0, "R13 partial");
        clk_bit(1'b0, 1'b0, "R13 partial");
        clk_bit(1'b1, 1'b0, "R13 partial");
        do_write(8'h20, 8'h5A, "R13 restarted write");
        do_rand_read(8'h20, 1, "R13 readback");

        // R11: power not good ignores the bus and clears the counter.
        por_ok = 1'b0;
        repeat (4) @(negedge clk);
        bus_start();
        put_byte(dsel(CE, 1'b0), 1'b0, "R11 deaf dev");
        put_byte(8'h30, 1'b0, "R11 deaf addr");
        put_byte(8'h99, 1'b0, "R11 deaf data");
        bus_stop();
        por_ok = 1'b1;
        ref_addr = 0;
        repeat (4) @(negedge clk);
        do_cur_read(1, "R11 counter cleared");
        do_rand_read(8'h30, 1, "R11 array untouched");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule